// File: doc/BRIEF.md
# Debug Trigger Chain Evaluator

This block turns the per-trigger local match flags of a set of debug triggers into chain trips for one instruction. Triggers are grouped into chains: a chain is a run of consecutive triggers that are linked by their chain bits. A set chain bit links a trigger to the next trigger. The first trigger whose chain bit is clear closes the chain. A chain trips only when every one of its members matched locally. When it trips, the block raises a hit-set strobe for every member.

The core presents one evaluation per instruction by pulsing `eval_go` with the local hits, chain bits, timing bits and action codes of that instruction. One cycle later the block presents one result cycle. That cycle carries the hit-set strobes, the number of tripped triggers with before timing and with after timing, and a request to enter debug mode. Nothing is carried from one evaluation into the next, so the match state is fresh at every instruction. An optional pair mode restricts chaining to an even-indexed trigger followed by its odd neighbour.

A two-state machine sequences the result. In `ST_IDLE` it waits; when `eval_go` is high it moves to `ST_DONE` (transition GO). `ST_DONE` is the result cycle. It stays in `ST_DONE` on another `eval_go` (transition AGAIN) and returns to `ST_IDLE` otherwise (transition RELEASE). Reset forces `ST_IDLE`.

Top module: `tce_chain_eval`

## Requirements
- R1: `res_valid` is high for exactly the one cycle after each cycle in which `eval_go` is sampled high. Whenever `res_valid` is low, `hit_set`, both counts and `dbg_req` are zero.
- R2: A trigger whose chain contains only itself trips exactly when its local hit is set and it is not suppressed.
- R3: A chain trips only when every member matched locally, and then `hit_set` is high for all of its members. Otherwise it is low for all of them.
- R4: The chain bit of the highest-indexed trigger is ignored; that trigger always closes its chain.
- R5: When `pair_mode` is 1, the chain bit of an odd-indexed trigger is ignored. Chains are then at most an even trigger followed by the next odd one.
- R6: `cnt_before` counts tripped triggers whose `time_after` bit is 0. `cnt_after` counts tripped triggers whose `time_after` bit is 1.
- R7: `dbg_req` is high in the result cycle when at least one tripped trigger has action code 1 (enter debug). A trigger with action code 1 that did not trip does not raise it.
- R8: A trigger with action code 0 (breakpoint exception) counts as unmatched while `irq_en` is 0. This blocks its whole chain. While `irq_en` is 1 it is treated like any other trigger.
- R9: Back-to-back evaluations are independent: each result depends only on the inputs sampled with its own `eval_go`.
- R10: During and right after reset, `res_valid`, `hit_set`, both counts and `dbg_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_go | input | 1 | Evaluate the inputs of this cycle |
| pair_mode | input | 1 | 1: chaining only from even trigger to next odd trigger |
| irq_en | input | 1 | Interrupts enabled; 0 suppresses action code 0 triggers |
| loc_hit | input | N_TRIG | Per-trigger local match |
| chain_bit | input | N_TRIG | Per-trigger link to the next trigger |
| time_after | input | N_TRIG | Per-trigger timing: 0 before, 1 after |
| act_code | input | N_TRIG*ACT_W | Action code of trigger i in bits [i*ACT_W +: ACT_W] |
| res_valid | output | 1 | Result cycle |
| hit_set | output | N_TRIG | Hit-set strobe per tripped trigger |
| cnt_before | output | CNT_W | Tripped triggers with before timing |
| cnt_after | output | CNT_W | Tripped triggers with after timing |
| dbg_req | output | 1 | Enter-debug request |

## Verification
The assertions check the one-cycle result timing and the silent outputs outside the result cycle on every cycle. They also check that both counts add up to the number of strobes, that a debug request never appears without a strobe, that a trigger without a local hit never gets a strobe, and that two linked triggers always share one outcome. Whether a chain trips as a whole, where pair mode and the last trigger cut chains, how interrupt suppression blocks a chain, and how triggers split by timing can only be shown by the bench. It compares every result cycle against an independent chain walk.

// File: rtl/tce_pkg.sv
package tce_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } tce_state_e;

    localparam int unsigned ACT_BREAK = 0;
    localparam int unsigned ACT_DEBUG = 1;

endpackage

// File: rtl/tce_link.sv
// Decides, per trigger, whether it links forward to the next trigger.
module tce_link #(
    parameter int N_TRIG = 8
) (
    input  logic              pair_mode,
    input  logic [N_TRIG-1:0] chain_bit,
    output logic [N_TRIG-1:0] link
);

    genvar gi;
    generate
        for (gi = 0; gi < N_TRIG; gi++) begin : g_lnk
            if (gi == N_TRIG - 1) begin : g_last
                // the highest trigger always closes its chain
                assign link[gi] = 1'b0;
            end else if ((gi % 2) == 1) begin : g_odd
                assign link[gi] = chain_bit[gi] & ~pair_mode;
            end else begin : g_even
                assign link[gi] = chain_bit[gi];
            end
        end
    endgenerate

endmodule

// File: rtl/tce_scan.sv
// A trigger trips when every member from its chain head up to it matched
// and every member from it down to its chain tail matched.
module tce_scan #(
    parameter int N_TRIG = 8
) (
    input  logic [N_TRIG-1:0] ok,
    input  logic [N_TRIG-1:0] link,
    output logic [N_TRIG-1:0] trip
);

    logic [N_TRIG-1:0] head_ok;
    logic [N_TRIG-1:0] tail_ok;

    always_comb begin
        head_ok[0] = ok[0];
        for (int i = 1; i < N_TRIG; i++) begin
            head_ok[i] = ok[i] & (~link[i-1] | head_ok[i-1]);
        end
    end

    always_comb begin
        tail_ok[N_TRIG-1] = ok[N_TRIG-1];
        for (int i = N_TRIG - 2; i >= 0; i--) begin
            tail_ok[i] = ok[i] & (~link[i] | tail_ok[i+1]);
        end
    end

    assign trip = head_ok & tail_ok;

endmodule

// File: rtl/tce_tally.sv
// Splits tripped triggers by timing and looks for an enter-debug action.
module tce_tally
    import tce_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int ACT_W  = 6,
    parameter int CNT_W  = 4
) (
    input  logic [N_TRIG-1:0]       trip,
    input  logic [N_TRIG-1:0]       time_after,
    input  logic [N_TRIG*ACT_W-1:0] act_code,
    output logic [CNT_W-1:0]        cnt_before,
    output logic [CNT_W-1:0]        cnt_after,
    output logic                    dbg
);

    localparam logic [ACT_W-1:0] DBG_CODE = ACT_W'(ACT_DEBUG);

    always_comb begin
        cnt_before = '0;
        cnt_after  = '0;
        dbg        = 1'b0;
        for (int i = 0; i < N_TRIG; i++) begin
            cnt_before = cnt_before + CNT_W'(trip[i] & ~time_after[i]);
            cnt_after  = cnt_after + CNT_W'(trip[i] & time_after[i]);
            if (trip[i] && (act_code[i*ACT_W +: ACT_W] == DBG_CODE)) begin
                dbg = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tce_chain_eval.sv
module tce_chain_eval
    import tce_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int ACT_W  = 6,
    parameter int CNT_W  = $clog2(N_TRIG + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    eval_go,
    input  logic                    pair_mode,
    input  logic                    irq_en,
    input  logic [N_TRIG-1:0]       loc_hit,
    input  logic [N_TRIG-1:0]       chain_bit,
    input  logic [N_TRIG-1:0]       time_after,
    input  logic [N_TRIG*ACT_W-1:0] act_code,
    output logic                    res_valid,
    output logic [N_TRIG-1:0]       hit_set,
    output logic [CNT_W-1:0]        cnt_before,
    output logic [CNT_W-1:0]        cnt_after,
    output logic                    dbg_req
);

    localparam logic [ACT_W-1:0] BRK_CODE = ACT_W'(ACT_BREAK);

    tce_state_e state_q, state_d;

    logic [N_TRIG-1:0] ok;
    logic [N_TRIG-1:0] link;
    logic [N_TRIG-1:0] trip;
    logic [CNT_W-1:0]  nb_c, na_c;
    logic              dbg_c;

    // suppression: breakpoint action with interrupts off counts as no match
    genvar gi;
    generate
        for (gi = 0; gi < N_TRIG; gi++) begin : g_ok
            assign ok[gi] = loc_hit[gi] &
                            ~(~irq_en & (act_code[gi*ACT_W +: ACT_W] == BRK_CODE));
        end
    endgenerate

    tce_link #(.N_TRIG(N_TRIG)) u_link (
        .pair_mode (pair_mode),
        .chain_bit (chain_bit),
        .link      (link)
    );

    tce_scan #(.N_TRIG(N_TRIG)) u_scan (
        .ok   (ok),
        .link (link),
        .trip (trip)
    );

    tce_tally #(.N_TRIG(N_TRIG), .ACT_W(ACT_W), .CNT_W(CNT_W)) u_tally (
        .trip       (trip),
        .time_after (time_after),
        .act_code   (act_code),
        .cnt_before (nb_c),
        .cnt_after  (na_c),
        .dbg        (dbg_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (eval_go) state_d = ST_DONE;          // GO
            ST_DONE: state_d = eval_go ? ST_DONE : ST_IDLE;   // AGAIN / RELEASE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers: loaded on each evaluation, cleared otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !eval_go) begin
            hit_set    <= '0;
            cnt_before <= '0;
            cnt_after  <= '0;
            dbg_req    <= 1'b0;
        end else begin
            hit_set    <= trip;
            cnt_before <= nb_c;
            cnt_after  <= na_c;
            dbg_req    <= dbg_c;
        end
    end

    assign res_valid = (state_q == ST_DONE);

endmodule

// File: rtl/tce_chain_eval_chk.sv
module tce_chain_eval_chk #(
    parameter int N_TRIG = 8,
    parameter int ACT_W  = 6,
    parameter int CNT_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    eval_go,
    input logic                    pair_mode,
    input logic                    irq_en,
    input logic [N_TRIG-1:0]       loc_hit,
    input logic [N_TRIG-1:0]       chain_bit,
    input logic [N_TRIG-1:0]       time_after,
    input logic [N_TRIG*ACT_W-1:0] act_code,
    input logic                    res_valid,
    input logic [N_TRIG-1:0]       hit_set,
    input logic [CNT_W-1:0]        cnt_before,
    input logic [CNT_W-1:0]        cnt_after,
    input logic                    dbg_req
);

    a_r1_valid_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        eval_go |=> res_valid);

    a_r1_no_valid_without_go: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_go |=> !res_valid);

    a_r1_quiet_outside_result: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (hit_set == '0 && cnt_before == '0 && cnt_after == '0 && !dbg_req));

    a_r6_counts_cover_hits: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (int'(cnt_before) + int'(cnt_after) == $countones(hit_set)));

    a_r7_debug_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> (hit_set != '0));

    genvar gi;
    generate
        for (gi = 0; gi < N_TRIG; gi++) begin : g_chk
            a_r2_hit_needs_local: assert property (@(posedge clk) disable iff (!rst_n)
                (eval_go && !loc_hit[gi]) |=> !hit_set[gi]);
            if (gi < N_TRIG - 1) begin : g_pair
                a_r3_linked_share_outcome: assert property (@(posedge clk) disable iff (!rst_n)
                    (eval_go && chain_bit[gi] && !(pair_mode && ((gi % 2) == 1)))
                    |=> (hit_set[gi] == hit_set[gi+1]));
            end
        end
    endgenerate

endmodule

bind tce_chain_eval tce_chain_eval_chk #(
    .N_TRIG (N_TRIG),
    .ACT_W  (ACT_W),
    .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/tb_tce_chain_eval.sv
`timescale 1ns/1ps
module tb_tce_chain_eval;

    localparam int N  = 8;
    localparam int AW = 6;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eval_go = 1'b0;
    logic pair_mode = 1'b0;
    logic irq_en = 1'b1;
    logic [N-1:0] loc_hit = '0;
    logic [N-1:0] chain_bit = '0;
    logic [N-1:0] time_after = '0;
    logic [N*AW-1:0] act_code = '0;
    logic res_valid;
    logic [N-1:0] hit_set;
    logic [CW-1:0] cnt_before, cnt_after;
    logic dbg_req;

    always #10 clk = ~clk;

    tce_chain_eval #(.N_TRIG(N), .ACT_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .eval_go(eval_go), .pair_mode(pair_mode),
        .irq_en(irq_en), .loc_hit(loc_hit), .chain_bit(chain_bit),
        .time_after(time_after), .act_code(act_code), .res_valid(res_valid),
        .hit_set(hit_set), .cnt_before(cnt_before), .cnt_after(cnt_after),
        .dbg_req(dbg_req)
    );

    typedef struct {
        logic [N-1:0] hit;
        int           nb;
        int           na;
        bit           dbg;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    function automatic logic [N*AW-1:0] acts_all(int v);
        logic [N*AW-1:0] r;
        for (int i = 0; i < N; i++) r[i*AW +: AW] = AW'(v);
        return r;
    endfunction

    // independent chain walk
    function automatic exp_t model(logic [N-1:0] lh, logic [N-1:0] ch, logic [N-1:0] ta,
                                   logic [N*AW-1:0] ac, bit pm, bit ie, string tag);
        exp_t e;
        int s;
        int k;
        bit all;
        e.hit = '0; e.nb = 0; e.na = 0; e.dbg = 0; e.tag = tag;
        s = 0;
        while (s < N) begin
            k = s;
            while (k < N - 1 && ch[k] && !(pm && (k % 2 == 1))) k++;
            all = 1;
            for (int j = s; j <= k; j++)
                if (!lh[j] || (!ie && ac[j*AW +: AW] == 0)) all = 0;
            if (all) begin
                for (int j = s; j <= k; j++) begin
                    e.hit[j] = 1'b1;
                    if (ta[j]) e.na++; else e.nb++;
                    if (ac[j*AW +: AW] == 1) e.dbg = 1;
                end
            end
            s = k + 1;
        end
        return e;
    endfunction

    task automatic run(string tag, logic [N-1:0] lh, logic [N-1:0] ch, logic [N-1:0] ta,
                       logic [N*AW-1:0] ac, bit pm, bit ie);
        loc_hit = lh; chain_bit = ch; time_after = ta; act_code = ac;
        pair_mode = pm; irq_en = ie; eval_go = 1'b1;
        sb.push_back(model(lh, ch, ta, ac, pm, ie, tag));
        @(negedge clk);
        eval_go = 1'b0;
    endtask

    task automatic gap();
        @(negedge clk);
    endtask

    // monitor: compares every result cycle, and silence outside it
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R1: result cycle with nothing expected, hit=%b", hit_set);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    checks++;
                    if (hit_set !== e.hit || int'(cnt_before) != e.nb ||
                        int'(cnt_after) != e.na || dbg_req !== e.dbg) begin
                        fails++;
                        $display("FAIL %s: got hit=%b nb=%0d na=%0d dbg=%0b exp hit=%b nb=%0d na=%0d dbg=%0b",
                                 e.tag, hit_set, cnt_before, cnt_after, dbg_req,
                                 e.hit, e.nb, e.na, e.dbg);
                    end
                end
            end else if (hit_set !== '0 || cnt_before !== '0 || cnt_after !== '0 || dbg_req !== 1'b0) begin
                checks++; fails++;
                $display("FAIL R1: outputs not quiet, got hit=%b dbg=%0b exp 0", hit_set, dbg_req);
            end
        end
    end

    initial begin : watchdog
        #(20 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] x;
        logic [N*AW-1:0] a2;
        a2 = acts_all(2);
        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (res_valid !== 1'b0 || hit_set !== '0 || dbg_req !== 1'b0 ||
            cnt_before !== '0 || cnt_after !== '0) begin
            fails++;
            $display("FAIL R10: reset outputs got v=%0b hit=%b exp 0", res_valid, hit_set);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || hit_set !== '0) begin
            fails++;
            $display("FAIL R10: after reset got v=%0b hit=%b exp 0", res_valid, hit_set);
        end

        // R2: lone triggers
        run("R2", 8'b0000_0101, 8'b0000_0000, 8'h00, a2, 0, 1); gap();
        // R3: four-member chain, all matched, then one missing
        run("R3", 8'b0000_1111, 8'b0000_0111, 8'h00, a2, 0, 1); gap();
        run("R3", 8'b0010_1011, 8'b0000_0111, 8'h00, a2, 0, 1); gap();
        // R4: last chain bit ignored
        run("R4", 8'b1100_0000, 8'b1100_0000, 8'h00, a2, 0, 1); gap();
        // R5: pair mode versus long chain
        run("R5", 8'b0000_0111, 8'hFF, 8'h00, a2, 1, 1); gap();
        run("R5", 8'b0000_0111, 8'hFF, 8'h00, a2, 0, 1); gap();
        run("R5", 8'b0000_0010, 8'b0000_0010, 8'h00, a2, 1, 1); gap();
        run("R5", 8'hFF, 8'hFF, 8'h00, a2, 1, 1); gap();
        // R6: timing split
        run("R6", 8'b1011_0111, 8'b0000_0000, 8'b1010_0101, a2, 0, 1); gap();
        // R7: debug action on tripped trigger, then on a trigger that did not trip
        begin
            logic [N*AW-1:0] ad;
            ad = a2; ad[3*AW +: AW] = AW'(1);
            run("R7", 8'b0000_1000, 8'h00, 8'h00, ad, 0, 1); gap();
            run("R7", 8'b0000_1000, 8'b0000_0100, 8'h00, ad, 0, 1); gap();
        end
        // R8: breakpoint action with interrupts off blocks its chain
        begin
            logic [N*AW-1:0] ab;
            ab = a2; ab[1*AW +: AW] = AW'(0);
            run("R8", 8'b0000_0111, 8'b0000_0011, 8'h00, ab, 0, 0); gap();
            run("R8", 8'b0000_0111, 8'b0000_0011, 8'h00, ab, 0, 1); gap();
        end
        // R9: back-to-back evaluations
        run("R9", 8'hFF, 8'h00, 8'h0F, a2, 0, 1);
        run("R9", 8'h01, 8'hFF, 8'h00, a2, 0, 1);
        run("R9", 8'b0011_0000, 8'b0001_0000, 8'hFF, a2, 0, 1); gap();

        // R3: pseudo-random mix
        x = 32'h1234_5678;
        for (int t = 0; t < 48; t++) begin
            logic [N*AW-1:0] ar;
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            for (int i = 0; i < N; i++) ar[i*AW +: AW] = AW'((x >> (i * 2)) & 3);
            run("R3", x[7:0] | x[15:8], x[23:16], x[31:24], ar, x[3], x[9]);
            if (x[20]) gap();
        end
        gap(); gap();

        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL R1: %0d results missing, exp 0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule